// File: doc/BRIEF.md
# Chainable Eight-Input Serial Frame Source

This block is the device-side logic of a serial input reader. When the host pulls chip select low, the block takes a snapshot of eight digital input levels and three supply/temperature condition bits. On each shift strobe after that, it moves the snapshot out one bit at a time, most significant bit first. A mode input sets the frame length. The short frame holds only the data byte and is the fast option. The long frame adds a status byte. That status byte carries a five-bit checksum of the data byte, so the host can detect a corrupted read, and also the three condition bits.

Bits presented on the serial input are shifted in behind the local frame. A downstream device's frame therefore leaves this block right after its own frame. Several blocks can be chained this way, and each device's frame starts one frame length further down the combined stream. A separate fault output follows the condition inputs continuously.

The shift strobe is a one-cycle pulse synchronous to the block clock, one per serial bit. Chip select is sampled on the same clock.

Top module: `input_serializer`

## Requirements
- R1: After reset, `ser_out` and `fault` are both 0.
- R2: On the first clock where `cs_n` is sampled low after being high (the load cycle), the block captures `din`, `mode_long` and the three condition inputs. From the next cycle, `ser_out` presents `din[7]`.
- R3: Each clock with `shift_en` high and `cs_n` low, outside a load cycle, advances the frame by one bit. The data byte leaves in the order `din[7]` down to `din[0]`.
- R4: When `mode_long` is 1 at load, the data byte is followed by a status byte. Status bits [7:3] hold the checksum. Bit 2 is `uv_alarm_n`, bit 1 is `over_temp` and bit 0 is `uv_warn_n`, all as captured at load. Status bits leave from bit 7 to bit 0.
- R5: The checksum is the remainder of the data byte times x^5, divided by x^5+x^4+x^2+1. Its x^4 coefficient is in status bit 7, so a data byte of 0x00 gives 0.
- R6: When `mode_long` is 0 at load, the frame is the data byte alone.
- R7: Bits sampled on `ser_in` at each shift come out on `ser_out` in the same order, right after the local frame (8 or 16 shifts later).
- R8: Changes on `din` or the condition inputs after the load cycle do not alter the frame being shifted.
- R9: Shift strobes while `cs_n` is high, or in the load cycle itself, do not move the frame.
- R10: `fault` is 1 in the cycle after any cycle where `over_temp` is 1, `uv_alarm_n` is 0 or `uv_warn_n` is 0. Otherwise it is 0.
- R11: A change of `mode_long` after the load cycle leaves the current frame length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low; its falling edge loads a frame |
| shift_en | input | 1 | One-cycle strobe per serial bit |
| mode_long | input | 1 | 1: data plus status frame, 0: data byte only |
| din | input | 8 | Digital input levels, bit n is input n |
| over_temp | input | 1 | Overtemperature condition, active high |
| uv_alarm_n | input | 1 | Primary undervoltage alarm, active low |
| uv_warn_n | input | 1 | Secondary undervoltage warning, active low |
| ser_in | input | 1 | Serial data from the downstream device |
| ser_out | output | 1 | Serial frame output |
| fault | output | 1 | Registered OR of the three active conditions |

## Verification
Several properties are checked on every clock:
- The shift register holds still on any cycle without a load or an accepted strobe.
- The frame length stays fixed between loads.
- The first long-frame bit follows a load.
- The fault register follows the condition inputs.
- An all-zero byte yields a zero checksum.

The bench's scenarios are the only evidence for the rest:
- the checksum value for non-trivial bytes;
- the order and position of the status flags;
- pass-through timing in both frame lengths;
- immunity to input changes during a frame;
- a shift strobe in the load cycle being discarded.

// File: rtl/iser_pkg.sv
package iser_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {
    FRAME_DATA_ONLY   = 1'b0,
    FRAME_WITH_STATUS = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/iser_crc.sv
module iser_crc #(
  parameter int unsigned          DATA_W = 8,
  parameter int unsigned          CRC_W  = 5,
  parameter logic [DATA_W-1:0]    POLY   = 8'hA8
) (
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  // One unrolled division step per data bit, polynomial left-aligned.
  logic [DATA_W-1:0] stage [0:DATA_W];

  assign stage[0] = data;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_step
      always_comb begin
        if (stage[gi][DATA_W-1]) begin
          stage[gi+1] = {stage[gi][DATA_W-2:0], 1'b0} ^ POLY;
        end else begin
          stage[gi+1] = {stage[gi][DATA_W-2:0], 1'b0};
        end
      end
    end
  endgenerate

  assign crc = stage[DATA_W][DATA_W-1 -: CRC_W];

  // R5: linear code, so an all-zero byte must give a zero remainder
  always_comb begin
    if (data == '0) begin
      a_r5_zero_crc: assert (crc == '0) else $error("R5 nonzero checksum of zero byte");
    end
  end
endmodule

// File: rtl/iser_shifter.sv
module iser_shifter
  import iser_pkg::*;
#(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic               long_in,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               ser_in,
  output logic               ser_out
);
  localparam int unsigned HALF_W = FRAME_W / 2;

  logic [FRAME_W-1:0] sr_q, sr_d;
  frame_kind_e        kind_q, kind_d;
  logic               en;

  assign en = load | shift;

  always_comb begin
    sr_d   = sr_q;
    kind_d = kind_q;
    if (load) begin
      sr_d   = frame_in;
      kind_d = long_in ? FRAME_WITH_STATUS : FRAME_DATA_ONLY;
    end else if (shift) begin
      sr_d = {sr_q[FRAME_W-2:0], ser_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      kind_q <= FRAME_DATA_ONLY;
    end else if (en) begin
      sr_q   <= sr_d;
      kind_q <= kind_d;
    end
  end

  // Tap point sets the frame length: the far end for long, mid-point for short.
  assign ser_out = (kind_q == FRAME_WITH_STATUS) ? sr_q[FRAME_W-1] : sr_q[HALF_W-1];

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sr_q))
    else $error("R9 frame moved without load or shift");

  a_r11_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(kind_q))
    else $error("R11 frame length changed between loads");

  a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (load && long_in) |=> (ser_out == $past(frame_in[FRAME_W-1])))
    else $error("R2 first bit after load wrong");
endmodule

// File: rtl/iser_monitor.sv
module iser_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic over_temp,
  input  logic uv_alarm_n,
  input  logic uv_warn_n,
  output logic fault
);
  logic fault_q, fault_d;

  always_comb begin
    fault_d = over_temp | ~uv_alarm_n | ~uv_warn_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

  a_r10_fault_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault == ($past(over_temp) | ~$past(uv_alarm_n) | ~$past(uv_warn_n))))
    else $error("R10 fault output mismatch");
endmodule

// File: rtl/input_serializer.sv
module input_serializer
  import iser_pkg::*;
#(
  parameter int unsigned       IN_W     = BYTE_W,
  parameter int unsigned       CRC_W    = 5,
  parameter logic [IN_W-1:0]   CRC_POLY = 8'hA8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            shift_en,
  input  logic            mode_long,
  input  logic [IN_W-1:0] din,
  input  logic            over_temp,
  input  logic            uv_alarm_n,
  input  logic            uv_warn_n,
  input  logic            ser_in,
  output logic            ser_out,
  output logic            fault
);
  localparam int unsigned FRAME_W = 2 * IN_W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Chip-select edge detect.
  logic cs_q, cs_d;
  logic load, shift_go;

  always_comb begin
    cs_d = cs_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_q <= 1'b1;
    end else begin
      cs_q <= cs_d;
    end
  end

  assign load     = ~cs_n & cs_q;
  assign shift_go = shift_en & ~cs_n & ~load;

  // Status byte assembly.
  logic [CRC_W-1:0]   crc;
  logic [IN_W-1:0]    status;
  logic [FRAME_W-1:0] frame_in;

  iser_crc #(
    .DATA_W (IN_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC_POLY)
  ) u_crc (
    .data (din),
    .crc  (crc)
  );

  assign status   = {crc, uv_alarm_n, over_temp, uv_warn_n};
  assign frame_in = mode_long ? {din, status} : {{IN_W{1'b0}}, din};

  iser_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .shift    (shift_go),
    .long_in  (mode_long),
    .frame_in (frame_in),
    .ser_in   (ser_in),
    .ser_out  (ser_out)
  );

  iser_monitor u_mon (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .over_temp  (over_temp),
    .uv_alarm_n (uv_alarm_n),
    .uv_warn_n  (uv_warn_n),
    .fault      (fault)
  );
endmodule

// File: tb/tb_input_serializer.sv
module tb_input_serializer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, cs_n, shift_en, mode_long, over_temp, uv_alarm_n, uv_warn_n, ser_in;
  logic [7:0] din;
  wire        ser_out, fault;

  int    n_run  = 0;
  int    n_fail = 0;
  string req    = "R1";
  logic  cmp_on = 1'b0;

  input_serializer dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .shift_en(shift_en), .mode_long(mode_long),
    .din(din), .over_temp(over_temp), .uv_alarm_n(uv_alarm_n), .uv_warn_n(uv_warn_n),
    .ser_in(ser_in), .ser_out(ser_out), .fault(fault)
  );

  // Remainder of d*x^5 modulo x^5+x^4+x^2+1 by long division.
  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b0};
    for (int i = 12; i >= 5; i--) begin
      if (r[i]) r = r ^ (13'h35 << (i - 5));
    end
    return r[4:0];
  endfunction

  task automatic check(input string r, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, got, exp);
    end
  endtask

  // Behavioural reference: a bit queue and a fault flag.
  bit   mq[$];
  logic m_cs, m_fault;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq = {};
      for (int i = 0; i < 8; i++) mq.push_back(1'b0);
      m_cs    = 1'b1;
      m_fault = 1'b0;
    end else begin
      if (!cs_n && m_cs) begin
        logic [7:0] st;
        mq = {};
        for (int i = 7; i >= 0; i--) mq.push_back(din[i]);
        if (mode_long) begin
          st = {ref_crc(din), uv_alarm_n, over_temp, uv_warn_n};
          for (int i = 7; i >= 0; i--) mq.push_back(st[i]);
        end
      end else if (shift_en && !cs_n) begin
        void'(mq.pop_front());
        mq.push_back(ser_in);
      end
      m_cs    = cs_n;
      m_fault = over_temp | ~uv_alarm_n | ~uv_warn_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(req, {31'b0, ser_out}, {31'b0, mq[0]}, "stream vs model");
      check("R10", {31'b0, fault}, {31'b0, m_fault}, "fault vs model");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // Runs one selection; `sin` is left-aligned, its MSB enters first.
  // At sample 2 the late values are applied to din / mode / over_temp.
  task automatic run_frame(input logic [7:0] d, input logic lng, input logic ot,
                           input logic uva, input logic uvw, input int nbits,
                           input logic [31:0] sin, input logic early,
                           input logic [7:0] d_late, input logic lng_late,
                           input logic ot_late, output logic [31:0] got);
    @(negedge clk);
    cs_n = 1'b1; shift_en = 1'b0; din = d; mode_long = lng;
    over_temp = ot; uv_alarm_n = uva; uv_warn_n = uvw;
    @(negedge clk);
    cs_n = 1'b0; shift_en = early; ser_in = 1'b1;
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      got = {got[30:0], ser_out};
      shift_en = 1'b1;
      ser_in   = sin[31-i];
      if (i == 2) begin
        din = d_late; mode_long = lng_late; over_temp = ot_late;
      end
    end
    @(negedge clk);
    shift_en = 1'b0; cs_n = 1'b1;
  endtask

  logic [31:0] got;
  logic [7:0]  st;

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; shift_en = 1'b0; mode_long = 1'b0; din = '0;
    over_temp = 1'b0; uv_alarm_n = 1'b1; uv_warn_n = 1'b1; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {31'b0, ser_out}, 32'd0, "ser_out after reset");
    check("R1", {31'b0, fault}, 32'd0, "fault after reset");
    cmp_on = 1'b1;

    // R2 R3 R4 R5: long frames over several data patterns and flag mixes
    req = "R4";
    begin
      logic [7:0] pats [6] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};
      for (int k = 0; k < 6; k++) begin
        logic a, b, c;
        a = k[0]; b = ~k[1]; c = ~k[2];
        run_frame(pats[k], 1'b1, a, b, c, 16, 32'h0, 1'b0, pats[k], 1'b1, a, got);
        st = {ref_crc(pats[k]), b, a, c};
        check("R4", got, {16'h0, pats[k], st}, "long frame data+status");
        check("R5", {27'b0, got[7:3]}, {27'b0, ref_crc(pats[k])}, "checksum field");
        check("R2", {31'b0, got[15]}, {31'b0, pats[k][7]}, "first bit is din[7]");
      end
    end
    check("R5", {27'b0, ref_crc(8'h00)}, 32'd0, "checksum of zero byte");

    // R6 R7: short frame followed by downstream bits
    req = "R6";
    run_frame(8'h96, 1'b0, 1'b0, 1'b1, 1'b1, 16, 32'hC3000000, 1'b0,
              8'h96, 1'b0, 1'b0, got);
    check("R6", {24'h0, got[15:8]}, 32'h96, "short frame data byte");
    check("R7", {24'h0, got[7:0]}, 32'hC3, "pass-through after short frame");

    // R7: long frame followed by downstream bits
    req = "R7";
    run_frame(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 24, 32'h6D000000, 1'b0,
              8'h5A, 1'b1, 1'b0, got);
    st = {ref_crc(8'h5A), 1'b1, 1'b0, 1'b0};
    check("R7", got, {8'h0, 8'h5A, st, 8'h6D}, "pass-through after long frame");

    // R8 R11: inputs and mode change mid-frame
    req = "R8";
    run_frame(8'h4E, 1'b1, 1'b0, 1'b1, 1'b1, 24, 32'hF0000000, 1'b0,
              8'hB1, 1'b0, 1'b1, got);
    st = {ref_crc(8'h4E), 1'b1, 1'b0, 1'b1};
    check("R8", got[23:8], {8'h4E, st}, "frame ignores late input change");
    check("R11", {24'h0, got[7:0]}, 32'hF0, "length kept after mode change");

    // R9: shift in the load cycle is discarded
    req = "R9";
    run_frame(8'hE7, 1'b0, 1'b0, 1'b1, 1'b1, 8, 32'h0, 1'b1,
              8'hE7, 1'b0, 1'b0, got);
    check("R9", got, 32'hE7, "strobe in load cycle ignored");

    // R9: strobes while deselected leave the output alone
    run_frame(8'h2B, 1'b1, 1'b0, 1'b1, 1'b1, 3, 32'h0, 1'b0,
              8'h2B, 1'b1, 1'b0, got);
    @(negedge clk);
    begin
      logic held;
      held = ser_out;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        shift_en = 1'b1; ser_in = i[0];
      end
      @(negedge clk);
      shift_en = 1'b0;
      @(negedge clk);
      check("R9", {31'b0, ser_out}, {31'b0, held}, "strobes with cs_n high ignored");
    end

    // R10: each condition alone and none
    req = "R10";
    begin
      logic [2:0] combos [5] = '{3'b011, 3'b111, 3'b001, 3'b010, 3'b011};
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        uv_alarm_n = combos[k][0]; uv_warn_n = combos[k][1]; over_temp = combos[k][2];
        @(negedge clk);
        check("R10", {31'b0, fault},
              {31'b0, combos[k][2] | ~combos[k][0] | ~combos[k][1]}, "fault level");
      end
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule